// File: doc/BRIEF.md
# Serial Data-Port Link Frame Transmitter

This block sits between a transmit word FIFO and the line encoder of a serial point-to-point data link. Each cycle it emits one 32-bit word with a control flag. A set flag marks a control code for the encoder, and a clear flag marks a payload word. When it has nothing to send it fills the line with an IDLE code. When words are waiting and the far end allows it, the block wraps them into bounded frames. Each frame has a start code that carries three sideband flag bits, a header code, the payload, an optional CRC-32 word and an end code. The end code tells plain data frames apart from synchronisation frames.

Each FIFO entry carries a 2-bit kind. It is a plain data word, a data word that ends a synchronised block, or a bare synchronisation marker with no data. A loop mode takes words from a received stream instead of the local FIFO, so a node can forward what it hears. A frame opens only when the transmitter is enabled, the far end signals GO and no retransmission is pending. A frame that loses its source, its enable or its GO closes cleanly on the next word.

Top module: `lnk_frame_tx`

## Requirements
- R1: During and after reset, out_word is the IDLE code 0xBC500000 with out_is_k = 1, and fifo_rd is low.
- R2: Every frame is emitted as one word per cycle in this order: a start code, then the header code 0xBC3C0000, then the payload words with out_is_k = 0 in source order, then the optional CRC, then an end code. At least two IDLE words follow each end code before the next start code. Overhead is five words per frame without CRC and six with it.
- R3: A frame carries at most MAX_WORDS payload words (512 by default). A longer burst continues in further frames.
- R4: A start code is emitted only when, in the cycle before, tx_en = 1, remote_go = 1, rtx_pending = 0, the selected source has a word and the IDLE gap is complete.
- R5: While a frame is open and remote_go = 0, tx_en = 0 or the source is empty, the next word closes the frame with the CRC (if enabled) or the end code, and no FIFO word is popped while remote_go = 0.
- R6: The start code is 0xBCF00000 OR'd with side_flags, sampled in the cycle before the start code appears.
- R7: Entry kind 1 is a data word that ends its frame, and that frame closes with end code 0xBCE00002. Entry kind 2 is a bare marker. At the head of a new frame it is consumed and gives a frame with no payload ending in 0xBCE00002. Met inside a frame, it first closes that frame with the data end code 0xBCE00001. Kind 0 and kind 3 are plain data.
- R8: With crc_en = 1, a control word holding the CRC-32 of the frame's payload sits between the last payload word and the end code. The CRC uses polynomial 0x04C11DB7, initial value all ones, each word fed MSB first, and the result inverted.
- R9: With loop_en = 1, payload comes from loop_data/loop_kind when loop_valid = 1, and fifo_rd stays low.
- R10: With tx_en = 0, no new frame starts. After any open frame closes, only IDLE words are sent.
- R11: rtx_pending = 1 blocks the start of a frame but does not cut a frame that is already open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| loop_en | input | 1 | Forward the received stream instead of FIFO data |
| crc_en | input | 1 | Append a CRC word to each frame |
| remote_go | input | 1 | Far-end flow control, 1 = GO, 0 = STOP |
| rtx_pending | input | 1 | Retransmission queue not empty |
| side_flags | input | 3 | Sideband flags folded into the start code |
| fifo_empty | input | 1 | Transmit FIFO has no word |
| fifo_data | input | 32 | Head word of the transmit FIFO (show-ahead) |
| fifo_kind | input | 2 | Kind of the head entry |
| fifo_rd | output | 1 | Pop the FIFO head at this clock edge |
| loop_valid | input | 1 | Received stream word present |
| loop_data | input | 32 | Received stream word |
| loop_kind | input | 2 | Kind of the received word |
| out_word | output | 32 | Word for the line encoder |
| out_is_k | output | 1 | 1 = control code, 0 = payload |

## Verification
The hardest case to reach is a bare synchronisation marker meeting the frame logic at each of its positions. The marker can arrive at the head of a new frame, behind data in an open frame, or right after a sync-ending data word. It must give the right split and the right end codes. The bench stops the far end with remote_go, preloads a whole mixed batch of entry kinds in one cycle, and then releases GO, so the block meets every marker position back to back. A behavioural model running beside it predicts each word and each pop. Separate phases cut an open frame with STOP, with tx_en and with an empty source, and run a 600-word burst across the length limit.

// File: rtl/lnk_frame_pkg.sv
package lnk_frame_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned KIND_W = 2;
  localparam int unsigned FLAG_W = 3;

  localparam logic [WORD_W-1:0] K_IDLE     = 32'hBC50_0000;
  localparam logic [WORD_W-1:0] K_SOF_BASE = 32'hBCF0_0000;
  localparam logic [WORD_W-1:0] K_HDR      = 32'hBC3C_0000;
  localparam logic [WORD_W-1:0] K_EOF_DATA = 32'hBCE0_0001;
  localparam logic [WORD_W-1:0] K_EOF_SYNC = 32'hBCE0_0002;

  localparam logic [KIND_W-1:0] KIND_DATA  = 2'd0;
  localparam logic [KIND_W-1:0] KIND_DSYNC = 2'd1;
  localparam logic [KIND_W-1:0] KIND_SONLY = 2'd2;

  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [WORD_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

  // State names describe the word emitted most recently.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_HDR,
    ST_PAY,
    ST_CRC,
    ST_EOF
  } fstate_t;

  function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] crc_in,
                                                 input logic [WORD_W-1:0] data);
    logic [WORD_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[WORD_W-1] ^ data[i];
      c  = {c[WORD_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] end_code(input logic is_sync);
    return is_sync ? K_EOF_SYNC : K_EOF_DATA;
  endfunction

endpackage

// File: rtl/lnk_src_mux.sv
module lnk_src_mux
  import lnk_frame_pkg::*;
(
  input  logic              loop_en,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic [KIND_W-1:0] fifo_kind,
  input  logic              loop_valid,
  input  logic [WORD_W-1:0] loop_data,
  input  logic [KIND_W-1:0] loop_kind,
  input  logic              take,
  output logic              src_avail,
  output logic [WORD_W-1:0] src_word,
  output logic [KIND_W-1:0] src_kind,
  output logic              fifo_rd
);

  always_comb begin
    if (loop_en) begin
      src_avail = loop_valid;
      src_word  = loop_data;
      src_kind  = loop_kind;
    end else begin
      src_avail = !fifo_empty;
      src_word  = fifo_data;
      src_kind  = fifo_kind;
    end
  end

  // Received-stream words are never held back, so a pop goes only to the FIFO.
  assign fifo_rd = take && !loop_en;

endmodule

// File: rtl/lnk_crc_acc.sv
module lnk_crc_acc
  import lnk_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] crc_val
);

  logic [WORD_W-1:0] crc_q, crc_n;
  logic              crc_ce;

  assign crc_ce = clr || upd;

  always_comb begin
    crc_n = crc_q;
    if (clr)      crc_n = CRC_INIT;
    else if (upd) crc_n = crc_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_INIT;
    else if (crc_ce) crc_q <= crc_n;
  end

  assign crc_val = ~crc_q;

endmodule

// File: rtl/lnk_frame_fsm.sv
module lnk_frame_fsm
  import lnk_frame_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 512,
  parameter int unsigned GAP_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              crc_en,
  input  logic              remote_go,
  input  logic              rtx_pending,
  input  logic [FLAG_W-1:0] side_flags,
  input  logic              src_avail,
  input  logic [WORD_W-1:0] src_word,
  input  logic [KIND_W-1:0] src_kind,
  input  logic [WORD_W-1:0] crc_val,
  output logic              take,
  output logic              crc_clr,
  output logic              crc_upd,
  output logic [WORD_W-1:0] out_word,
  output logic              out_is_k
);

  localparam int unsigned CNT_W = $clog2(MAX_WORDS + 1);
  localparam int unsigned GAP_W = $clog2(GAP_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_WORDS);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_WORDS);

  fstate_t           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [GAP_W-1:0]  gap_q, gap_n;
  logic              sync_q, sync_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic              k_q, k_n;

  logic start_ok, end_frame, do_close, close_sync;

  assign start_ok  = tx_en && remote_go && !rtx_pending && src_avail;
  assign end_frame = !tx_en || !remote_go || !src_avail || sync_q ||
                     (cnt_q == CNT_MAX) ||
                     ((src_kind == KIND_SONLY) && (cnt_q != '0));

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    gap_n      = gap_q;
    sync_n     = sync_q;
    word_n     = K_IDLE;
    k_n        = 1'b1;
    take       = 1'b0;
    crc_clr    = 1'b0;
    crc_upd    = 1'b0;
    do_close   = 1'b0;
    close_sync = sync_q;
    unique case (st_q)
      ST_IDLE: begin
        if (gap_q < GAP_MAX) begin
          gap_n = gap_q + 1'b1;
        end else if (start_ok) begin
          word_n  = K_SOF_BASE | WORD_W'(side_flags);
          st_n    = ST_SOF;
          cnt_n   = '0;
          sync_n  = 1'b0;
          crc_clr = 1'b1;
        end
      end
      ST_SOF: begin
        word_n = K_HDR;
        st_n   = ST_HDR;
      end
      ST_HDR, ST_PAY: begin
        if (end_frame) begin
          do_close = 1'b1;
        end else if (src_kind == KIND_SONLY) begin
          take       = 1'b1;
          do_close   = 1'b1;
          close_sync = 1'b1;
        end else begin
          take    = 1'b1;
          word_n  = src_word;
          k_n     = 1'b0;
          cnt_n   = cnt_q + 1'b1;
          crc_upd = 1'b1;
          sync_n  = (src_kind == KIND_DSYNC);
          st_n    = ST_PAY;
        end
      end
      ST_CRC: begin
        word_n = end_code(sync_q);
        st_n   = ST_EOF;
      end
      ST_EOF: begin
        gap_n = GAP_W'(1);
        st_n  = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    if (do_close) begin
      sync_n = close_sync;
      if (crc_en) begin
        word_n = crc_val;
        st_n   = ST_CRC;
      end else begin
        word_n = end_code(close_sync);
        st_n   = ST_EOF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      gap_q  <= GAP_MAX;
      sync_q <= 1'b0;
      word_q <= K_IDLE;
      k_q    <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      gap_q  <= gap_n;
      sync_q <= sync_n;
      word_q <= word_n;
      k_q    <= k_n;
    end
  end

  assign out_word = word_q;
  assign out_is_k = k_q;

  a_r3_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX)
    else $error("R3: payload count above limit");

  a_r7_sync_last: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY && sync_q) |=> (k_q == 1'b1))
    else $error("R7: payload followed a sync-ending word");

  a_r2_gap_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EOF) |=> (st_q == ST_IDLE && word_q == K_IDLE && k_q))
    else $error("R2: no idle after end code");

endmodule

// File: rtl/lnk_frame_tx.sv
module lnk_frame_tx
  import lnk_frame_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 512,
  parameter int unsigned GAP_WORDS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        loop_en,
  input  logic        crc_en,
  input  logic        remote_go,
  input  logic        rtx_pending,
  input  logic [2:0]  side_flags,
  input  logic        fifo_empty,
  input  logic [31:0] fifo_data,
  input  logic [1:0]  fifo_kind,
  output logic        fifo_rd,
  input  logic        loop_valid,
  input  logic [31:0] loop_data,
  input  logic [1:0]  loop_kind,
  output logic [31:0] out_word,
  output logic        out_is_k
);

  logic              src_avail, take, crc_clr, crc_upd;
  logic [WORD_W-1:0] src_word, crc_val;
  logic [KIND_W-1:0] src_kind;

  lnk_src_mux u_src (
    .loop_en    (loop_en),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .fifo_kind  (fifo_kind),
    .loop_valid (loop_valid),
    .loop_data  (loop_data),
    .loop_kind  (loop_kind),
    .take       (take),
    .src_avail  (src_avail),
    .src_word   (src_word),
    .src_kind   (src_kind),
    .fifo_rd    (fifo_rd)
  );

  lnk_crc_acc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (crc_clr),
    .upd     (crc_upd),
    .din     (src_word),
    .crc_val (crc_val)
  );

  lnk_frame_fsm #(
    .MAX_WORDS (MAX_WORDS),
    .GAP_WORDS (GAP_WORDS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .crc_en      (crc_en),
    .remote_go   (remote_go),
    .rtx_pending (rtx_pending),
    .side_flags  (side_flags),
    .src_avail   (src_avail),
    .src_word    (src_word),
    .src_kind    (src_kind),
    .crc_val     (crc_val),
    .take        (take),
    .crc_clr     (crc_clr),
    .crc_upd     (crc_upd),
    .out_word    (out_word),
    .out_is_k    (out_is_k)
  );

  logic sof_seen, open_word;
  assign sof_seen  = out_is_k && (out_word[31:3] == K_SOF_BASE[31:3]);
  assign open_word = !out_is_k || (out_word == K_HDR);

  a_r4_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    sof_seen |-> $past(tx_en && remote_go && !rtx_pending))
    else $error("R4: frame opened without permission");

  a_r6_flags_in_sof: assert property (@(posedge clk) disable iff (!rst_n)
    sof_seen |-> (out_word[2:0] == $past(side_flags)))
    else $error("R6: start code flags mismatch");

  a_r2_hdr_after_sof: assert property (@(posedge clk) disable iff (!rst_n)
    sof_seen |=> (out_is_k && out_word == K_HDR))
    else $error("R2: header missing after start code");

  a_r5_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (open_word && !remote_go) |=> out_is_k)
    else $error("R5: payload sent under STOP");

  a_r5_no_pop_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !remote_go |-> !fifo_rd)
    else $error("R5: FIFO popped under STOP");

  a_r9_loop_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !out_is_k) |-> !fifo_rd)
    else $error("R9: FIFO read in loop mode");

endmodule

// File: tb/lnk_frame_tx_tb.sv
module lnk_frame_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 512;
  localparam logic [31:0] IDLE_C = 32'hBC50_0000;
  localparam logic [31:0] SOF_C  = 32'hBCF0_0000;
  localparam logic [31:0] HDR_C  = 32'hBC3C_0000;
  localparam logic [31:0] EOFD_C = 32'hBCE0_0001;
  localparam logic [31:0] EOFS_C = 32'hBCE0_0002;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0, loop_en = 1'b0, crc_en = 1'b0;
  logic        remote_go = 1'b0, rtx_pending = 1'b0;
  logic [2:0]  side_flags = 3'd0;
  logic        fifo_empty = 1'b1;
  logic [31:0] fifo_data = 32'd0;
  logic [1:0]  fifo_kind = 2'd0;
  logic        fifo_rd;
  logic        loop_valid = 1'b0;
  logic [31:0] loop_data = 32'd0;
  logic [1:0]  loop_kind = 2'd0;
  logic [31:0] out_word;
  logic        out_is_k;

  int tests = 0, fails = 0, cycles = 0;
  logic running = 1'b0;
  logic [33:0] q[$];
  logic pop_pend = 1'b0;

  // model state
  int mst = 0, mgap = 2, mcnt = 0;
  logic msync = 1'b0;
  logic [31:0] mcrc = 32'hFFFF_FFFF;
  logic [31:0] exp_w = IDLE_C;
  logic exp_k = 1'b1;
  string exp_tag = "R1";

  // monitor counters
  int sof_cnt = 0, eofs_cnt = 0, eofd_cnt = 0, run = 0, max_run = 0, crc_words = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .loop_en(loop_en), .crc_en(crc_en),
    .remote_go(remote_go), .rtx_pending(rtx_pending), .side_flags(side_flags),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_kind(fifo_kind),
    .fifo_rd(fifo_rd), .loop_valid(loop_valid), .loop_data(loop_data),
    .loop_kind(loop_kind), .out_word(out_word), .out_is_k(out_is_k)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 31; b >= 0; b--) begin
      if (r[31] ^ d[b]) r = (r << 1) ^ 32'h04C1_1DB7;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [31:0] w, input logic [1:0] k);
    q.push_back({k, w});
  endtask

  // bench FIFO: pop and refresh away from the edge
  always @(posedge clk) begin
    #1;
    if (pop_pend) begin
      void'(q.pop_front());
      pop_pend = 1'b0;
    end
    #1;
    fifo_empty = (q.size() == 0);
    fifo_data  = (q.size() != 0) ? q[0][31:0] : 32'd0;
    fifo_kind  = (q.size() != 0) ? q[0][33:32] : 2'd0;
  end

  // compare and model step at the falling edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      logic av; logic [31:0] sw; logic [1:0] sk;
      logic pop, do_close, csync;
      logic [31:0] nw; logic nk; string tg;
      chk(out_word === exp_w && out_is_k === exp_k, exp_tag, out_word, exp_w);
      if (out_is_k) begin
        if (run > max_run) max_run = run;
        run = 0;
        if (out_word[31:3] == SOF_C[31:3]) sof_cnt++;
        if (out_word == EOFS_C) eofs_cnt++;
        if (out_word == EOFD_C) eofd_cnt++;
      end else run++;
      if (loop_en) begin av = loop_valid; sw = loop_data; sk = loop_kind; end
      else begin
        av = (q.size() != 0);
        sw = av ? q[0][31:0] : 32'd0;
        sk = av ? q[0][33:32] : 2'd0;
      end
      pop = 0; do_close = 0; csync = msync; nw = IDLE_C; nk = 1; tg = "R2";
      case (mst)
        0: begin
          if (mgap < 2) mgap++;
          else if (tx_en && remote_go && !rtx_pending && av) begin
            nw = SOF_C | {29'd0, side_flags}; mst = 1; mcnt = 0; msync = 0;
            mcrc = 32'hFFFF_FFFF; tg = "R6";
          end else tg = "R4";
        end
        1: begin nw = HDR_C; mst = 2; end
        2, 3: begin
          if (!tx_en || !remote_go || !av || msync || mcnt == MAXW ||
              (sk == 2'd2 && mcnt != 0)) begin
            do_close = 1; tg = "R5";
          end else if (sk == 2'd2) begin
            pop = 1; do_close = 1; csync = 1; tg = "R7";
          end else begin
            pop = 1; nw = sw; nk = 0; mcnt++; mcrc = crc_ref(mcrc, sw);
            msync = (sk == 2'd1); mst = 3; tg = loop_en ? "R9" : "R3";
          end
        end
        4: begin nw = msync ? EOFS_C : EOFD_C; mst = 5; tg = "R7"; end
        default: begin mgap = 1; mst = 0; end
      endcase
      if (do_close) begin
        msync = csync;
        if (crc_en) begin nw = ~mcrc; mst = 4; tg = "R8"; crc_words++; end
        else begin nw = csync ? EOFS_C : EOFD_C; mst = 5; end
      end
      chk(fifo_rd === (pop && !loop_en), loop_en ? "R9 fifo_rd" : "R5 fifo_rd",
          {31'd0, fifo_rd}, {31'd0, pop && !loop_en});
      if (pop && !loop_en) pop_pend = 1'b1;
      exp_w = nw; exp_k = nk; exp_tag = tg;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic settle(input int n);
    int guard = 0;
    while ((q.size() != 0 || mst != 0) && guard < 5000) begin tick(); guard++; end
    repeat (n) tick();
  endtask

  initial begin
    int s0, s1, f0, es0, ed0;
    repeat (3) tick();
    chk(out_word === IDLE_C && out_is_k === 1'b1, "R1 reset word", out_word, IDLE_C);
    chk(fifo_rd === 1'b0, "R1 reset fifo_rd", {31'd0, fifo_rd}, 32'd0);
    rst_n = 1'b1;
    running = 1'b1;
    tick();
    tx_en = 1; remote_go = 1; side_flags = 3'b101;

    // R2/R6: simple frame
    for (int i = 0; i < 5; i++) push(32'h1000_0000 + i, 2'd0);
    settle(4);
    chk(sof_cnt == 1, "R2 one frame", sof_cnt, 1);

    // R8: CRC frame with other flags
    crc_en = 1; side_flags = 3'b010;
    push(32'hDEAD_BEEF, 2'd0); push(32'h0123_4567, 2'd3); push(32'h89AB_CDEF, 2'd0);
    settle(4);
    chk(crc_words == 1, "R8 crc word count", crc_words, 1);
    crc_en = 0;

    // R3: long burst splits
    f0 = sof_cnt;
    for (int i = 0; i < 600; i++) push(32'h2000_0000 + i, 2'd0);
    settle(4);
    chk(max_run == MAXW, "R3 max payload run", max_run, MAXW);
    chk(sof_cnt - f0 == 2, "R3 frames for burst", sof_cnt - f0, 2);

    // R7: sync kinds, preloaded under STOP
    remote_go = 0;
    es0 = eofs_cnt; ed0 = eofd_cnt;
    push(32'h3000_0001, 2'd0); push(32'h3000_0002, 2'd0); push(32'h3000_0003, 2'd1);
    push(32'h0, 2'd2); push(32'h3000_0005, 2'd0); push(32'h3000_0006, 2'd0);
    push(32'h0, 2'd2); push(32'h3000_0008, 2'd0);
    tick(); tick();
    remote_go = 1;
    settle(4);
    chk(eofs_cnt - es0 == 3, "R7 sync end codes", eofs_cnt - es0, 3);
    chk(eofd_cnt - ed0 == 2, "R7 data end codes", eofd_cnt - ed0, 2);

    // R5: STOP mid-frame
    for (int i = 0; i < 40; i++) push(32'h4000_0000 + i, 2'd0);
    repeat (10) tick();
    remote_go = 0;
    tick();
    s0 = q.size();
    repeat (8) tick();
    s1 = q.size();
    chk(s0 == s1 && s0 > 0, "R5 no pop under STOP", s1, s0);
    remote_go = 1;
    settle(4);

    // R11: retransmit pending blocks start
    rtx_pending = 1; f0 = sof_cnt;
    for (int i = 0; i < 5; i++) push(32'h5000_0000 + i, 2'd0);
    repeat (20) tick();
    chk(q.size() == 5, "R11 fifo held", q.size(), 5);
    chk(sof_cnt == f0, "R11 no start", sof_cnt, f0);
    rtx_pending = 0;
    settle(4);
    // R11: pending raised inside an open frame does not cut it
    for (int i = 0; i < 30; i++) push(32'h5100_0000 + i, 2'd0);
    repeat (8) tick();
    rtx_pending = 1;
    repeat (40) tick();
    chk(q.size() == 0, "R11 open frame completes", q.size(), 0);
    rtx_pending = 0;
    settle(4);

    // R10: transmitter disabled
    tx_en = 0; f0 = sof_cnt;
    for (int i = 0; i < 6; i++) push(32'h6000_0000 + i, 2'd0);
    repeat (30) tick();
    chk(sof_cnt == f0 && q.size() == 6, "R10 idle when disabled", sof_cnt, f0);
    tx_en = 1;
    repeat (6) tick();
    tx_en = 0;
    repeat (20) tick();
    tx_en = 1;
    settle(4);

    // R9: loop mode
    loop_en = 1;
    for (int i = 0; i < 4; i++) push(32'h7000_0000 + i, 2'd0);
    for (int i = 0; i < 40; i++) begin
      loop_valid = (i % 7) != 6; loop_data = 32'hA500_0000 + i; loop_kind = 2'd0;
      tick();
    end
    loop_valid = 0;
    repeat (10) tick();
    chk(q.size() == 4, "R9 fifo untouched", q.size(), 4);
    loop_en = 0;
    settle(4);
    chk(q.size() == 0, "R9 fifo drained after loop", q.size(), 0);

    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule